// File: doc/BRIEF.md
# Bus Controller Host Register Interface

This block sits between a host processor and the word-level machinery of a serial avionics bus controller. The host sees a 4-bit register address and a 16-bit data bus with separate read and write strobes. Behind that sit a control register, a 32-word transmit data queue and a 32-word receive data queue. The control register sets the operating mode, the transmit bus, the reply time-out length and the clock range. It can also supply register address bits, trigger a master reset and start a message sequence.

The Manchester encoder takes transmit words from a valid/ready stream. The decoder delivers received words into a second valid/ready stream. The protocol sequencer watches the one-cycle start strobe. Address and mode bits are the OR of register bits and input pins, so either hardware or software can drive them. Master reset empties both queues but leaves the control register alone. Each message start also flushes the receive queue.

Back-pressure rules: a transmit word leaves when `tx_valid` and `tx_ready` are both high at a rising clock edge, and `tx_data` holds the oldest word while `tx_valid` is high. A received word is taken when `rx_valid` and `rx_ready` are both high. `rx_ready` drops while the receive queue is full, during master reset and in the cycle of the start strobe, and the sender must then hold its word.

Top module: `bc_host_regs`

## Requirements
- R1: The effective register address is `host_addr` ORed with control bits 10:7. A write to any effective address with bit 2 set loads the control register. A read at 1100 returns it. A write at any effective address whose low three bits are 010 goes to the transmit queue. A read at 0100 pops the receive queue. Any other read returns 0. Read data appears on `host_rdata` in the cycle after the read strobe.
- R2: Control bit 11 is reserved and always reads back as 0. Bit 14 drives `gap_long` and bit 12 drives `clk_half`.
- R3: `op_mode` is {bit3 OR `rt_pin`, bit2 OR `bc_pin`}. The codes are 00 for monitor with terminal address, 01 for bus controller, 10 for remote terminal and 11 for monitor without terminal address.
- R4: Control bit 4 alone enables bus A and bit 5 alone enables bus B. Both set, or neither set, enables no bus. `txinh_a` and `txinh_b` force their own bus enable low.
- R5: `msg_start` is high for exactly one cycle, the cycle after a control write that sets bit 1 while the stored bit 1 is 0. No pulse comes while master reset is active or being written. Re-writing 1 gives no pulse.
- R6: `mres` is high while control bit 0 or `mr_pin` is high. It empties both queues and clears `ovf_flag`, but the control register keeps its value. Only `rst_n` clears the control register.
- R7: The transmit queue holds 32 words. Words leave on the transmit stream in write order, and `tx_valid` is high whenever the queue is not empty.
- R8: A host write to a full transmit queue is dropped and sets `ovf_flag`. The flag stays set until master reset.
- R9: The receive queue holds 32 words. `rx_ready` is low when the queue is full, during `mres`, and while `msg_start` is high.
- R10: The receive queue is empty in the cycle after `msg_start`.
- R11: `rx_empty` is high when no received word waits, and it rises when the host reads the last word. A read of an empty receive queue returns 0 and changes nothing.
- R12: A received word accepted in the same cycle as a host receive read is stored. The read returns the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mr_pin | input | 1 | External master reset, active high |
| host_addr | input | 4 | Host register address pins |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data, registered |
| rt_pin | input | 1 | Remote-terminal mode pin |
| bc_pin | input | 1 | Bus-controller mode pin |
| txinh_a | input | 1 | Transmit inhibit, bus A |
| txinh_b | input | 1 | Transmit inhibit, bus B |
| op_mode | output | 2 | Decoded operating mode |
| bus_a_en | output | 1 | Transmit enabled on bus A |
| bus_b_en | output | 1 | Transmit enabled on bus B |
| gap_long | output | 1 | Long reply time-out selected |
| clk_half | output | 1 | Lower input clock range selected |
| mres | output | 1 | Master reset active |
| msg_start | output | 1 | One-cycle message start strobe |
| tx_data | output | 16 | Transmit stream word |
| tx_valid | output | 1 | Transmit stream valid |
| tx_ready | input | 1 | Transmit stream ready from encoder |
| rx_data | input | 16 | Receive stream word from decoder |
| rx_valid | input | 1 | Receive stream valid |
| rx_ready | output | 1 | Receive stream ready |
| rx_empty | output | 1 | Receive queue empty |
| ovf_flag | output | 1 | Sticky write-to-full-queue flag |

## Verification
The receive queue can take a word from the decoder and lose a word to a host read at the same clock edge. The bench preloads two words, then raises `rx_valid` and a host read at 0100 in one cycle. The read must return the oldest word, and the following reads must produce the second preloaded word and then the new one before `rx_empty` rises. The start strobe and the receive stream are a second pair that meets in one cycle. That case is judged by `rx_ready` being low in the strobe cycle and the queue being empty just after it.

// File: rtl/bc_host_pkg.sv
package bc_host_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int Q_DEPTH = 32;

  // control register bit positions
  localparam int CB_MRES  = 0;
  localparam int CB_START = 1;
  localparam int CB_BCM   = 2;
  localparam int CB_RTM   = 3;
  localparam int CB_TXA   = 4;
  localparam int CB_TXB   = 5;
  localparam int CB_RA_LO = 7;
  localparam int CB_RSVD  = 11;
  localparam int CB_CLK   = 12;
  localparam int CB_GAP   = 14;

  localparam logic [ADDR_W-1:0] ADR_CTRL_RD = 4'b1100;
  localparam logic [ADDR_W-1:0] ADR_RX_RD   = 4'b0100;
  localparam logic [2:0]        ADR_TX_LOW  = 3'b010;
  localparam int                ADR_CTRL_WR_BIT = 2;

  typedef enum logic [1:0] {
    MODE_MON_ADDR   = 2'b00,
    MODE_BC         = 2'b01,
    MODE_RT         = 2'b10,
    MODE_MON_NOADDR = 2'b11
  } op_mode_e;
endpackage

// File: rtl/bc_word_fifo.sv
module bc_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/bc_ctrl_reg.sv
module bc_ctrl_reg
  import bc_host_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          mr_pin,
  input  logic          rt_pin,
  input  logic          bc_pin,
  input  logic          txinh_a,
  input  logic          txinh_b,
  output logic [AW-1:0] eff_addr,
  output logic [DW-1:0] ctrl_q,
  output logic          ctrl_wr,
  output logic          msg_start,
  output logic          mres,
  output logic [1:0]    op_mode,
  output logic          bus_a_en,
  output logic          bus_b_en
);
  localparam logic [DW-1:0] RSVD_MASK = DW'(1) << CB_RSVD;

  op_mode_e mode_w;
  logic     start_req;

  assign eff_addr = host_addr | ctrl_q[CB_RA_LO +: AW];
  assign ctrl_wr  = host_wr && eff_addr[ADR_CTRL_WR_BIT];
  assign mres     = ctrl_q[CB_MRES] | mr_pin;

  assign start_req = ctrl_wr && host_wdata[CB_START] && !ctrl_q[CB_START]
                     && !mres && !host_wdata[CB_MRES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      msg_start <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= host_wdata & ~RSVD_MASK;
      msg_start <= start_req;
    end
  end

  assign mode_w   = op_mode_e'({ctrl_q[CB_RTM] | rt_pin, ctrl_q[CB_BCM] | bc_pin});
  assign op_mode  = mode_w;
  assign bus_a_en = ctrl_q[CB_TXA] && !ctrl_q[CB_TXB] && !txinh_a;
  assign bus_b_en = ctrl_q[CB_TXB] && !ctrl_q[CB_TXA] && !txinh_b;
endmodule

// File: rtl/bc_host_regs.sv
module bc_host_regs
  import bc_host_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int DEPTH = Q_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_pin,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          rt_pin,
  input  logic          bc_pin,
  input  logic          txinh_a,
  input  logic          txinh_b,
  output logic [1:0]    op_mode,
  output logic          bus_a_en,
  output logic          bus_b_en,
  output logic          gap_long,
  output logic          clk_half,
  output logic          mres,
  output logic          msg_start,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          rx_empty,
  output logic          ovf_flag
);
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] ctrl_q, rx_head;
  logic          ctrl_wr, ctrl_rd_sel, rx_rd_sel, tx_wr_sel;
  logic          tx_full, tx_empty, tx_ovf, rx_full, rx_ovf;

  bc_ctrl_reg #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .mr_pin(mr_pin), .rt_pin(rt_pin), .bc_pin(bc_pin),
    .txinh_a(txinh_a), .txinh_b(txinh_b), .eff_addr(eff_addr), .ctrl_q(ctrl_q),
    .ctrl_wr(ctrl_wr), .msg_start(msg_start), .mres(mres), .op_mode(op_mode),
    .bus_a_en(bus_a_en), .bus_b_en(bus_b_en)
  );

  assign tx_wr_sel   = host_wr && (eff_addr[2:0] == ADR_TX_LOW);
  assign ctrl_rd_sel = host_rd && (eff_addr == ADR_CTRL_RD);
  assign rx_rd_sel   = host_rd && (eff_addr == ADR_RX_RD);

  bc_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(mres), .push(tx_wr_sel),
    .pop(tx_valid && tx_ready), .wdata(host_wdata), .rdata(tx_data),
    .full(tx_full), .empty(tx_empty), .ovf(tx_ovf)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full && !mres && !msg_start;

  bc_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(mres || msg_start),
    .push(rx_valid && rx_ready), .pop(rx_rd_sel), .wdata(rx_data),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty), .ovf(rx_ovf)
  );

  // receive side is protected by rx_ready, so only the transmit queue can set this
  assign ovf_flag = tx_ovf | rx_ovf;
  assign gap_long = ctrl_q[CB_GAP];
  assign clk_half = ctrl_q[CB_CLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      if (ctrl_rd_sel)                host_rdata <= ctrl_q;
      else if (rx_rd_sel && !rx_empty) host_rdata <= rx_head;
      else                            host_rdata <= '0;
    end
  end

  // tx_full is only used through the queue's own drop logic
  logic unused_ok;
  assign unused_ok = tx_full;
endmodule

// File: rtl/bc_host_regs_chk.sv
module bc_host_regs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_start,
  input logic          mres,
  input logic          bus_a_en,
  input logic          bus_b_en,
  input logic          rx_empty,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          ctrl_wr,
  input logic          rx_rd_sel,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] host_rdata
);
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> !msg_start);

  a_r4_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_a_en && bus_b_en));

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[11] == 1'b0);

  a_r6_mres_empties: assert property (@(posedge clk) disable iff (!rst_n)
    mres |=> (rx_empty && !tx_valid));

  a_r6_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mres && !ctrl_wr) |=> $stable(ctrl_q));

  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mres || msg_start) |-> !rx_ready);

  a_r10_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> rx_empty);

  a_r11_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_sel && rx_empty) |=> (host_rdata == '0));
endmodule

bind bc_host_regs bc_host_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .mres(mres),
  .bus_a_en(bus_a_en), .bus_b_en(bus_b_en), .rx_empty(rx_empty),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .ctrl_wr(ctrl_wr),
  .rx_rd_sel(rx_rd_sel), .ctrl_q(ctrl_q), .host_rdata(host_rdata)
);

// File: tb/sim_bc_host_regs.sv
module sim_bc_host_regs;
  logic        clk = 0, rst_n = 0, mr_pin = 0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata, tx_data, rx_data = '0;
  logic        host_wr = 0, host_rd = 0, rt_pin = 0, bc_pin = 0;
  logic        txinh_a = 0, txinh_b = 0, bus_a_en, bus_b_en, gap_long, clk_half;
  logic        mres, msg_start, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic        rx_empty, ovf_flag;
  logic [1:0]  op_mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bc_host_regs u0 (.*);

  // {ctrl bits 5:2} {rt_pin, bc_pin, txinh_a, txinh_b} {mode, bus_a, bus_b}
  localparam logic [11:0] VEC [13] = '{
    12'b0000_0000_0000, 12'b0001_0000_0100, 12'b0010_0000_1000,
    12'b0011_0000_1100, 12'b0100_0000_0010, 12'b1000_0000_0001,
    12'b1100_0000_0000, 12'b0100_0010_0000, 12'b1000_0010_0001,
    12'b1000_0001_0000, 12'b0000_1000_1000, 12'b0001_1000_1100,
    12'b0010_0100_1100
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(posedge clk); @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [15:0] d);
    host_addr = a; host_rd = 1;
    @(posedge clk); @(negedge clk);
    host_rd = 0; d = host_rdata;
  endtask

  task automatic rxpush(input logic [15:0] d);
    rx_data = d; rx_valid = 1;
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    bit pulsed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(op_mode == 2'b00 && !bus_a_en && !bus_b_en, "R3 reset mode/bus", {op_mode, bus_a_en, bus_b_en}, 0);
    chk(rx_empty && !tx_valid && !msg_start && !mres && !ovf_flag, "R6 reset flags",
        {rx_empty, tx_valid, msg_start, mres, ovf_flag}, 5'b10000);
    hrd(4'b1100, d);
    chk(d == 16'h0000, "R1 reset ctrl read", d, 0);

    // table walk: mode and bus selection
    foreach (VEC[i]) begin
      rt_pin = VEC[i][7]; bc_pin = VEC[i][6]; txinh_a = VEC[i][5]; txinh_b = VEC[i][4];
      hwr(4'b0100, {10'd0, VEC[i][11:8], 2'b00});
      chk(op_mode == VEC[i][3:2], $sformatf("R3 vec %0d mode", i), op_mode, VEC[i][3:2]);
      chk({bus_a_en, bus_b_en} == VEC[i][1:0], $sformatf("R4 vec %0d bus", i),
          {bus_a_en, bus_b_en}, VEC[i][1:0]);
    end
    rt_pin = 0; bc_pin = 0; txinh_a = 0; txinh_b = 0;

    // R2 reserved bit, gap and clock bits
    hwr(4'b0100, 16'h5800);
    hrd(4'b1100, d);
    chk(d == 16'h5000, "R2 reserved bit reads 0", d, 16'h5000);
    chk(gap_long && clk_half, "R2 gap/clk outputs", {gap_long, clk_half}, 2'b11);

    // R1 address OR: ctrl bits 10:7 = 1000 turn pin address 0100 into 1100
    hwr(4'b0100, 16'h0400);
    hrd(4'b0100, d);
    chk(d == 16'h0400, "R1 OR address read ctrl", d, 16'h0400);
    hwr(4'b0100, 16'h0000);
    hrd(4'b0011, d);
    chk(d == 16'h0000, "R1 unmapped read is 0", d, 0);

    // R7/R8 transmit queue
    for (int i = 0; i < 32; i++) hwr(4'b1010, 16'hA000 + 16'(i));
    chk(!ovf_flag && tx_valid, "R8 no overflow at 32", {ovf_flag, tx_valid}, 2'b01);
    hwr(4'b0010, 16'hBEEF);
    chk(ovf_flag, "R8 overflow on 33rd write", ovf_flag, 1);
    tx_ready = 1;
    for (int i = 0; i < 32; i++) begin
      chk(tx_valid && tx_data == 16'hA000 + 16'(i), "R7 transmit order", tx_data, 16'hA000 + 16'(i));
      @(posedge clk); @(negedge clk);
    end
    tx_ready = 0;
    chk(!tx_valid, "R8 dropped word absent", tx_valid, 0);
    chk(ovf_flag, "R8 flag sticky", ovf_flag, 1);

    // R5 start strobe
    hwr(4'b0100, 16'h0002);
    chk(msg_start, "R5 start pulse", msg_start, 1);
    @(negedge clk);
    chk(!msg_start, "R5 pulse one cycle", msg_start, 0);
    hwr(4'b0100, 16'h0002);
    chk(!msg_start, "R5 no pulse on rewrite", msg_start, 0);
    hwr(4'b0100, 16'h0000);

    // R11 receive read and empty flag
    rxpush(16'h1111); rxpush(16'h2222);
    chk(!rx_empty, "R11 data waiting", rx_empty, 0);
    hrd(4'b0100, d);
    chk(d == 16'h1111, "R11 first word", d, 16'h1111);
    hrd(4'b0100, d);
    chk(d == 16'h2222 && rx_empty, "R11 last read sets empty", {d, rx_empty}, {16'h2222, 1'b1});
    hrd(4'b0100, d);
    chk(d == 16'h0000 && rx_empty, "R11 empty read is 0", d, 0);

    // R12 simultaneous push and host read
    rxpush(16'h3333); rxpush(16'h4444);
    rx_data = 16'h5555; rx_valid = 1; host_addr = 4'b0100; host_rd = 1;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; host_rd = 0;
    chk(host_rdata == 16'h3333, "R12 read returns oldest", host_rdata, 16'h3333);
    hrd(4'b0100, d);
    chk(d == 16'h4444, "R12 second word", d, 16'h4444);
    hrd(4'b0100, d);
    chk(d == 16'h5555 && rx_empty, "R12 pushed word kept", d, 16'h5555);

    // R9 full receive queue
    for (int i = 0; i < 32; i++) rxpush(16'hC000 + 16'(i));
    chk(!rx_ready, "R9 ready low when full", rx_ready, 0);

    // R10 start flush, ready low in strobe cycle
    hwr(4'b0100, 16'h0002);
    chk(msg_start && !rx_ready, "R9 ready low during start", {msg_start, rx_ready}, 2'b10);
    @(negedge clk);
    chk(rx_empty, "R10 flush on start", rx_empty, 1);

    // R6 master reset via control bit, control kept
    hwr(4'b0100, 16'h0010);
    rxpush(16'h7777);
    hwr(4'b0010, 16'h8888);
    hwr(4'b0100, 16'h0011);
    chk(mres, "R6 mres from bit", mres, 1);
    hwr(4'b0100, 16'h0010);
    chk(rx_empty && !tx_valid && !ovf_flag, "R6 queues cleared",
        {rx_empty, tx_valid, ovf_flag}, 3'b100);
    chk(bus_a_en, "R6 control kept", bus_a_en, 1);

    // R6 master reset via pin, R5 no start during reset
    rxpush(16'h9999);
    mr_pin = 1;
    hwr(4'b0100, 16'h0012);
    pulsed = msg_start;
    @(negedge clk);
    mr_pin = 0;
    chk(!pulsed, "R5 no start under reset", pulsed, 0);
    chk(rx_empty, "R6 pin clears receive queue", rx_empty, 1);
    hrd(4'b1100, d);
    chk(d == 16'h0012, "R6 control survives pin reset", d, 16'h0012);

    finish_run();
  end
endmodule